// File: doc/BRIEF.md
# Pause-Width Modulated Frame Encoder

This block sends one reader-to-card frame of up to 16 bits by switching a carrier-enable line. Each bit opens with a short carrier-off gap of fixed length. The carrier-on time that follows sets the total bit length, and that length carries the bit value. Before encoding, every payload bit is XORed with the matching bit of a supplied keystream word. After the last bit, one more gap closes the frame.

All durations are counted in ticks of a one-per-microsecond enable input, so the block runs from any system clock. A frame starts on a single-cycle strobe that carries the data word, the keystream word and the bit count. The block reports that it is working and gives a one-cycle completion pulse. The keystream source, the analog front end and any logging are outside this block.

Top module: `pause_frame_encoder`

## Requirements
- R1: After reset and whenever no frame is in progress, `carrier_o` is 1, `busy_o` is 0 and `done_o` is 0.
- R2: Every bit begins with `carrier_o` at 0 for PAUSE_US ticks (default 20).
- R3: A transmitted 1 keeps `carrier_o` at 1 for ONE_ON_US ticks (default 80) after its gap, for a 100-tick bit.
- R4: A transmitted 0 keeps `carrier_o` at 1 for ZERO_ON_US ticks (default 40) after its gap, for a 60-tick bit.
- R5: Bits leave least significant first (bit 0 of the word first). The frame holds exactly `nbits_i` bits. A count above MAX_BITS (16) is treated as 16. A count of 0 sends only the closing gap.
- R6: Transmitted bit i equals `data_i[i] ^ key_i[i]`, both sampled in the cycle `start_i` is accepted.
- R7: After the last bit, `carrier_o` is 0 for PAUSE_US ticks and then returns to 1. `busy_o` falls and `done_o` is 1 for exactly one clock in the cycle after the clock edge that sees the gap's final tick.
- R8: `start_i` while `busy_o` is 1 is ignored, and the frame in progress is unchanged. A start in the cycle `done_o` is high is accepted.
- R9: Timing advances only on clock edges where `tick_i` is 1. Between such edges, `carrier_o` and `busy_o` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-per-microsecond timing enable |
| start_i | input | 1 | Frame start strobe |
| data_i | input | 16 | Payload word, bit 0 sent first |
| key_i | input | 16 | Keystream word XORed onto the payload |
| nbits_i | input | 5 | Number of bits to send |
| carrier_o | output | 1 | Carrier enable, 1 = on |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle pulse at frame end |

## Verification
The hardest situations to reach are where timing events coincide at a clock edge:
- the final tail tick meets a new start strobe;
- `tick_i` is high on every cycle, so interval boundaries sit on adjacent edges;
- a start arrives mid-frame with different parameters.

The bench makes these happen by driving starts in the exact cycle `done_o` rises and by switching the tick spacing between one and several clocks. It also issues a second start while busy, then confirms at the ports that the carrier waveform and the frame length match the first request only. A behavioural model builds a per-tick queue of expected carrier levels from the requirements and compares all outputs on every clock.

// File: rtl/pfe_pkg.sv
package pfe_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_GAP   = 2'd1,
    ST_MARK  = 2'd2,
    ST_TAIL  = 2'd3
  } pfe_state_e;
endpackage

// File: rtl/pfe_interval_timer.sv
module pfe_interval_timer #(
  parameter int TW = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          run_i,
  input  logic          tick_i,
  input  logic [TW-1:0] target_i,
  output logic          expire_o
);
  logic [TW-1:0] cnt_q;

  assign expire_o = run_i && tick_i && (cnt_q == target_i - TW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (clear_i || expire_o) cnt_q <= '0;
    else if (run_i && tick_i)     cnt_q <= cnt_q + TW'(1);
  end

  // count never passes the current interval length
  p_cnt_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_q < target_i));

  p_hold_no_tick_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !tick_i && !clear_i) |=> $stable(cnt_q));
endmodule

// File: rtl/pfe_bit_shifter.sv
module pfe_bit_shifter #(
  parameter int MAX_BITS = 16,
  parameter int LEN_W    = $clog2(MAX_BITS + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic                shift_i,
  input  logic [MAX_BITS-1:0] data_i,
  input  logic [MAX_BITS-1:0] key_i,
  input  logic [LEN_W-1:0]    len_i,
  output logic                cur_bit_o,
  output logic                last_o
);
  logic [MAX_BITS-1:0] sreg_q;
  logic [LEN_W-1:0]    rem_q;

  assign cur_bit_o = sreg_q[0];
  assign last_o    = (rem_q == LEN_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sreg_q <= '0;
      rem_q  <= '0;
    end else if (load_i) begin
      sreg_q <= data_i ^ key_i;
      rem_q  <= len_i;
    end else if (shift_i) begin
      sreg_q <= {1'b0, sreg_q[MAX_BITS-1:1]};
      rem_q  <= rem_q - LEN_W'(1);
    end
  end

  p_no_underflow_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i |-> (rem_q != '0));

  p_rem_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rem_q <= LEN_W'(MAX_BITS));
endmodule

// File: rtl/pfe_ctrl.sv
module pfe_ctrl
  import pfe_pkg::*;
#(
  parameter int TW         = 7,
  parameter int PAUSE_US   = 20,
  parameter int ONE_ON_US  = 80,
  parameter int ZERO_ON_US = 40
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          zero_len_i,
  input  logic          expire_i,
  input  logic          cur_bit_i,
  input  logic          last_i,
  output logic          accept_o,
  output logic          shift_o,
  output logic          run_o,
  output logic [TW-1:0] target_o,
  output logic          carrier_o,
  output logic          busy_o,
  output logic          done_o
);
  pfe_state_e state_q, state_d;
  logic       done_q;

  assign accept_o  = (state_q == ST_IDLE) && start_i;
  assign shift_o   = (state_q == ST_MARK) && expire_i;
  assign run_o     = (state_q != ST_IDLE);
  assign carrier_o = (state_q == ST_IDLE) || (state_q == ST_MARK);
  assign busy_o    = run_o;
  assign done_o    = done_q;

  always_comb begin
    unique case (state_q)
      ST_MARK: target_o = cur_bit_i ? TW'(ONE_ON_US) : TW'(ZERO_ON_US);
      default: target_o = TW'(PAUSE_US);
    endcase
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_i)  state_d = zero_len_i ? ST_TAIL : ST_GAP;
      ST_GAP:  if (expire_i) state_d = ST_MARK;
      ST_MARK: if (expire_i) state_d = last_i ? ST_TAIL : ST_GAP;
      ST_TAIL: if (expire_i) state_d = ST_IDLE;
      default:               state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= (state_q == ST_TAIL) && expire_i;
    end
  end

  p_done_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);

  p_busy_while_start_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && !expire_i) |=> busy_o);
endmodule

// File: rtl/pause_frame_encoder.sv
module pause_frame_encoder #(
  parameter int MAX_BITS   = 16,
  parameter int PAUSE_US   = 20,
  parameter int ONE_ON_US  = 80,
  parameter int ZERO_ON_US = 40
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  input  logic                start_i,
  input  logic [MAX_BITS-1:0] data_i,
  input  logic [MAX_BITS-1:0] key_i,
  input  logic [$clog2(MAX_BITS+1)-1:0] nbits_i,
  output logic                carrier_o,
  output logic                busy_o,
  output logic                done_o
);
  localparam int LEN_W  = $clog2(MAX_BITS + 1);
  localparam int MAX_ON = (ONE_ON_US > ZERO_ON_US) ? ONE_ON_US : ZERO_ON_US;
  localparam int MAX_D  = (MAX_ON > PAUSE_US) ? MAX_ON : PAUSE_US;
  localparam int TW     = $clog2(MAX_D + 1);

  logic             accept, shift, run, expire, cur_bit, last_bit, zero_len;
  logic [TW-1:0]    target;
  logic [LEN_W-1:0] len_eff;

  assign len_eff  = (nbits_i > LEN_W'(MAX_BITS)) ? LEN_W'(MAX_BITS) : nbits_i;
  assign zero_len = (nbits_i == '0);

  pfe_ctrl #(
    .TW(TW), .PAUSE_US(PAUSE_US), .ONE_ON_US(ONE_ON_US), .ZERO_ON_US(ZERO_ON_US)
  ) u_ctrl (
    .clk_i, .rst_ni,
    .start_i, .zero_len_i(zero_len), .expire_i(expire),
    .cur_bit_i(cur_bit), .last_i(last_bit),
    .accept_o(accept), .shift_o(shift), .run_o(run), .target_o(target),
    .carrier_o, .busy_o, .done_o
  );

  pfe_interval_timer #(.TW(TW)) u_timer (
    .clk_i, .rst_ni,
    .clear_i(accept), .run_i(run), .tick_i, .target_i(target), .expire_o(expire)
  );

  pfe_bit_shifter #(.MAX_BITS(MAX_BITS), .LEN_W(LEN_W)) u_shift (
    .clk_i, .rst_ni,
    .load_i(accept), .shift_i(shift),
    .data_i, .key_i, .len_i(len_eff),
    .cur_bit_o(cur_bit), .last_o(last_bit)
  );

  p_idle_carrier_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> carrier_o);

  p_done_ends_busy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> (!busy_o && $past(busy_o)));

  p_stable_no_tick_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !tick_i) |=> ($stable(carrier_o) && busy_o));
endmodule

// File: tb/pause_frame_encoder_tb.sv
module pause_frame_encoder_tb;
  localparam int CLK_PERIOD = 10;
  localparam int MB         = 16;
  localparam int GAP        = 20;
  localparam int ON1        = 80;
  localparam int ON0        = 40;

  logic          clk = 0;
  logic          rst_n = 0;
  logic          tick = 0;
  logic          start = 0;
  logic [MB-1:0] data = '0;
  logic [MB-1:0] key = '0;
  logic [4:0]    nbits = '0;
  logic          carrier, busy, done;

  int checks = 0;
  int errors = 0;
  int tdiv = 1;
  int tcnt = 0;
  int q[$];
  logic exp_done = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pause_frame_encoder u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .start_i(start),
    .data_i(data), .key_i(key), .nbits_i(nbits),
    .carrier_o(carrier), .busy_o(busy), .done_o(done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // reference model: one queue entry per tick of expected carrier level
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete();
      exp_done = 0;
    end else begin
      exp_done = 0;
      if (q.size() > 0) begin
        if (tick) begin
          void'(q.pop_front());
          if (q.size() == 0) exp_done = 1;
        end
      end else if (start) begin
        int n;
        logic [MB-1:0] w;
        n = (nbits > MB) ? MB : int'(nbits);
        w = data ^ key;
        for (int i = 0; i < n; i++) begin
          for (int j = 0; j < GAP; j++) q.push_back(0);
          for (int j = 0; j < (w[i] ? ON1 : ON0); j++) q.push_back(1);
        end
        for (int j = 0; j < GAP; j++) q.push_back(0);
      end
    end
  end

  // compare every cycle, then drive tick
  always @(negedge clk) begin
    if (rst_n) begin
      int ec;
      ec = (q.size() > 0) ? q[0] : 1;
      check(carrier == ec, "R2 R3 R4 R5 R6 carrier", carrier, ec);
      check(busy == (q.size() > 0), "R8 R9 busy", busy, q.size() > 0);
      check(done == exp_done, "R7 done", done, exp_done);
    end
    tcnt = (tcnt + 1 >= tdiv) ? 0 : tcnt + 1;
    tick = (tcnt == 0);
  end

  task automatic send(input logic [MB-1:0] d, input logic [MB-1:0] k, input int n);
    @(negedge clk);
    start = 1; data = d; key = k; nbits = 5'(n);
    @(negedge clk);
    start = 0;
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int cyc, pulses;
    #(CLK_PERIOD * 3);
    // R1 reset state
    check(carrier == 1 && busy == 0 && done == 0, "R1 reset", {carrier, busy, done}, 3'b100);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R5 R6: 7 bits, plain
    tdiv = 1;
    send(16'h0055, 16'h0000, 7);
    wait_done();

    // R3 R4 R6 R7: 6 bits, keyed -> 0x1B, 4 ones 2 zeros = 540 ticks
    @(negedge clk);
    start = 1; data = 16'h003D; key = 16'h0026; nbits = 5'd6;
    @(negedge clk);
    start = 0;
    cyc = 1;
    pulses = 0;
    while (busy) begin
      @(negedge clk);
      if (busy) cyc++;
      if (done) pulses++;
    end
    check(cyc == 540, "R3 R4 R6 frame length", cyc, 540);
    repeat (2) @(negedge clk);
    check(pulses == 1, "R7 single done pulse", pulses, 1);

    // slower tick, R9
    tdiv = 4;
    send(16'hFFFF, 16'h0000, 16);
    wait_done();
    send(16'hFFFF, 16'hFFFF, 16);
    wait_done();

    // R5 zero length and clamp
    tdiv = 3;
    send(16'hA5C3, 16'h0000, 0);
    wait_done();
    send(16'hA5C3, 16'h0F0F, 20);
    wait_done();

    // R8: start while busy ignored; length matches the first request
    tdiv = 1;
    send(16'h0000, 16'h0000, 2);
    start = 1; data = 16'hFFFF; nbits = 5'd16;
    @(negedge clk);
    start = 0;
    cyc = 2;
    while (busy) begin
      @(negedge clk);
      if (busy) cyc++;
    end
    check(cyc == 2 * 60 + 20, "R8 ignored start length", cyc, 140);

    // R8: start accepted in the done cycle
    tdiv = 2;
    send(16'h0001, 16'h0000, 3);
    wait_done();
    start = 1; data = 16'h0002; key = 16'h0000; nbits = 5'd2;
    @(negedge clk);
    start = 0;
    check(busy == 1, "R8 restart at done", busy, 1);
    wait_done();

    repeat (5) @(negedge clk);
    check(carrier == 1 && busy == 0, "R1 idle after frames", {carrier, busy}, 2'b10);
    finish_run();
  end
endmodule